// File: doc/BRIEF.md
# Parallel NOR Flash Program/Erase Sequencer

This block sits on the host side of an asynchronous, byte-wide NOR flash. It takes one request at a time, programming a single byte, erasing any chosen set of sectors, or erasing the whole device. It turns that request into the flash's software command protocol: a fixed run of unlock writes, a command code, and the final target write or writes. It then polls the device until the embedded operation inside the flash has finished. The exact bus-cycle timing is handled by a separate bus-cycle engine. This sequencer only hands that engine one read or write at a time through a request/acknowledge pair. For a read, the engine returns the bit it sampled on the data line's most significant bit.

Completion is decided by polling, with no fixed wait. While the flash is busy, bit 7 of a read at the target reads as the inverse of the value being written. Once the bit shows the final value, the sequencer raises a one-cycle done pulse. Each operation type has its own cycle limit, which the host supplies. If polling runs past that limit, done comes with the error flag set and the sequencer goes back to idle. The sector number is taken from the top address bits, and each sector spans 64 KB of the 512 KB space.

Top module: `nor_flash_seq`

## Requirements
- R1: Byte program (op code 2'b00) issues four writes in this order: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, then the request address with the request data byte.
- R2: Chip erase (op code 2'b10) issues six writes in this order: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x10.
- R3: Sector erase (op code 2'b01) issues the first five chip-erase writes. It then writes 0x30 to the base address {k, 16'h0000} of each sector k whose mask bit k is set, in ascending k, one write directly after another.
- R4: After the last command write, the block issues reads at a poll address. For program this is the request address, for sector erase the base of the lowest selected sector, and for chip erase address 0. The first read whose bit 7 equals the expected bit ends the operation with done_o high for exactly one cycle and err_o low. The expected bit is data bit 7 for program and 1 for either erase.
- R5: A cycle counter starts at zero when polling begins and counts the polling cycles. A non-matching read that completes while the counter is at or above the limit for the current op (prog_limit_i, serase_limit_i or cerase_limit_i) ends the operation with done_o and err_o both high.
- R6: ack_o is high only when req_i is high and the block is idle. busy_o is high from the cycle after an accepted request until the operation ends, and it is low in the cycle done_o is high. A request made while busy is not acknowledged and has no effect on the bus.
- R7: bus_req_o stays high, with address, write flag and write data unchanged, until bus_ack_i is seen. Each bus_ack_i completes exactly one transfer.
- R8: A request with op code 2'b11, or a sector erase with an all-zero mask, is acknowledged and answered in the next cycle with done_o and err_o high. No bus transfer is made.
- R9: After reset, busy_o, done_o, err_o and bus_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Operation request |
| ack_o | output | 1 | Request accepted this cycle |
| op_i | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 invalid |
| addr_i | input | AW (19) | Byte address for program |
| data_i | input | 8 | Byte to program |
| sect_mask_i | input | NSECT (8) | Sectors to erase, bit k selects sector k |
| prog_limit_i | input | CW (24) | Poll cycle limit for program |
| serase_limit_i | input | CW (24) | Poll cycle limit for sector erase |
| cerase_limit_i | input | CW (24) | Poll cycle limit for chip erase |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| err_o | output | 1 | With done_o: timeout or rejected request |
| bus_req_o | output | 1 | Transfer request to the bus-cycle engine |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | AW (19) | Transfer address |
| bus_wdata_o | output | 8 | Write data |
| bus_ack_i | input | 1 | Transfer completed this cycle |
| bus_rbit7_i | input | 1 | Bit 7 of the byte read, valid with bus_ack_i |

## Verification
The assertions assume that bus_ack_i only comes while bus_req_o is high and lasts one cycle per transfer. They also assume that the limit inputs and request fields are stable in the cycle a request is accepted. The bench's bus responder answers only a pending request, pulses the acknowledge for a single cycle, and always leaves at least one idle cycle between acknowledges. Request fields are driven away from the clock edge and are held until the acknowledge has been sampled.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_CERASE = 2'd2,
    OP_BAD    = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_POLL  = 2'd2
  } st_e;

  typedef struct packed {
    logic [15:0] a;
    logic [7:0]  d;
  } cmd_word_t;

  localparam logic [15:0] KEY_ADDR_HI = 16'h5555;
  localparam logic [15:0] KEY_ADDR_LO = 16'h2AAA;
  localparam logic [7:0]  KEY_DATA_HI = 8'hAA;
  localparam logic [7:0]  KEY_DATA_LO = 8'h55;
  localparam logic [7:0]  CODE_PROG   = 8'hA0;
  localparam logic [7:0]  CODE_ERASE  = 8'h80;
  localparam logic [7:0]  CODE_CHIP   = 8'h10;
  localparam logic [7:0]  CODE_SECT   = 8'h30;

  // Fixed part of every command: step index -> address/data pair.
  function automatic cmd_word_t fixed_word(op_e op, logic [2:0] idx);
    cmd_word_t w;
    case (idx)
      3'd0:    w = '{KEY_ADDR_HI, KEY_DATA_HI};
      3'd1:    w = '{KEY_ADDR_LO, KEY_DATA_LO};
      3'd2:    w = '{KEY_ADDR_HI, (op == OP_PROG) ? CODE_PROG : CODE_ERASE};
      3'd3:    w = '{KEY_ADDR_HI, KEY_DATA_HI};
      3'd4:    w = '{KEY_ADDR_LO, KEY_DATA_LO};
      default: w = '{KEY_ADDR_HI, (op == OP_CERASE) ? CODE_CHIP : CODE_SECT};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/nor_seq_cmdgen.sv
module nor_seq_cmdgen
  import nor_seq_pkg::*;
#(
  parameter int AW    = 19,
  parameter int NSECT = 8,
  localparam int SW   = $clog2(NSECT)
) (
  input  op_e              op,
  input  logic [2:0]       idx,
  input  logic [NSECT-1:0] rem,
  input  logic [NSECT-1:0] sel,
  input  logic [AW-1:0]    tgt_addr,
  input  logic [7:0]       tgt_data,
  output logic [AW-1:0]    cmd_addr,
  output logic [7:0]       cmd_data,
  output logic             cmd_last,
  output logic [NSECT-1:0] pick,
  output logic [AW-1:0]    poll_addr,
  output logic             poll_bit
);

  function automatic logic [SW-1:0] first_idx(logic [NSECT-1:0] m);
    logic [SW-1:0] k;
    k = '0;
    for (int i = NSECT - 1; i >= 0; i--) begin
      if (m[i]) k = SW'(i);
    end
    return k;
  endfunction

  function automatic logic [AW-1:0] sect_base(logic [SW-1:0] k);
    return {k, {(AW - SW){1'b0}}};
  endfunction

  cmd_word_t w;

  // lowest remaining sector, as a one-hot vector
  assign pick = rem & (~rem + NSECT'(1));

  always_comb begin
    w        = fixed_word(op, idx);
    cmd_addr = AW'(w.a);
    cmd_data = w.d;
    cmd_last = 1'b0;
    if (op == OP_PROG && idx == 3'd3) begin
      cmd_addr = tgt_addr;
      cmd_data = tgt_data;
      cmd_last = 1'b1;
    end else if (idx == 3'd5) begin
      if (op == OP_SERASE) begin
        cmd_addr = sect_base(first_idx(rem));
        cmd_last = ((rem & ~pick) == '0);
      end else begin
        cmd_last = 1'b1;
      end
    end
  end

  always_comb begin
    case (op)
      OP_PROG:   poll_addr = tgt_addr;
      OP_SERASE: poll_addr = sect_base(first_idx(sel));
      default:   poll_addr = '0;
    endcase
    poll_bit = (op == OP_PROG) ? tgt_data[7] : 1'b1;
  end

endmodule

// File: rtl/nor_seq_timer.sv
module nor_seq_timer #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          expired
);

  logic [CW-1:0] cnt;

  assign expired = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + CW'(1);
  end

  // R5
  expiry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && expired && run |=> !run || expired);

  // R5
  count_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

endmodule

// File: rtl/nor_flash_seq.sv
module nor_flash_seq
  import nor_seq_pkg::*;
#(
  parameter int AW    = 19,
  parameter int NSECT = 8,
  parameter int CW    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  output logic             ack_o,
  input  logic [1:0]       op_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [7:0]       data_i,
  input  logic [NSECT-1:0] sect_mask_i,
  input  logic [CW-1:0]    prog_limit_i,
  input  logic [CW-1:0]    serase_limit_i,
  input  logic [CW-1:0]    cerase_limit_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [7:0]       bus_wdata_o,
  input  logic             bus_ack_i,
  input  logic             bus_rbit7_i
);

  st_e              st;
  op_e              op_q;
  logic [AW-1:0]    addr_q;
  logic [7:0]       data_q;
  logic [NSECT-1:0] sel_q, rem_q;
  logic [2:0]       idx_q;
  logic [CW-1:0]    limit_q, limit_in;
  logic             done_q, err_q;

  logic [AW-1:0]    cmd_addr, poll_addr;
  logic [7:0]       cmd_data;
  logic             cmd_last, poll_bit, expired;
  logic [NSECT-1:0] pick;

  // named events for the assertions
  op_e  op_in;
  logic accept, bad_req, poll_hit, poll_fail;

  assign op_in     = op_e'(op_i);
  assign accept    = req_i && (st == ST_IDLE);
  assign bad_req   = (op_in == OP_BAD) || (op_in == OP_SERASE && sect_mask_i == '0);
  assign poll_hit  = (st == ST_POLL) && bus_ack_i && (bus_rbit7_i == poll_bit);
  assign poll_fail = (st == ST_POLL) && bus_ack_i && (bus_rbit7_i != poll_bit) && expired;

  always_comb begin
    case (op_in)
      OP_PROG:   limit_in = prog_limit_i;
      OP_SERASE: limit_in = serase_limit_i;
      default:   limit_in = cerase_limit_i;
    endcase
  end

  nor_seq_cmdgen #(.AW(AW), .NSECT(NSECT)) u_cmdgen (
    .op(op_q), .idx(idx_q), .rem(rem_q), .sel(sel_q),
    .tgt_addr(addr_q), .tgt_data(data_q),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_last(cmd_last),
    .pick(pick), .poll_addr(poll_addr), .poll_bit(poll_bit)
  );

  nor_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st == ST_POLL),
    .limit(limit_q), .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      sel_q   <= '0;
      rem_q   <= '0;
      idx_q   <= '0;
      limit_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          op_q    <= op_in;
          addr_q  <= addr_i;
          data_q  <= data_i;
          sel_q   <= sect_mask_i;
          rem_q   <= sect_mask_i;
          idx_q   <= '0;
          limit_q <= limit_in;
          if (bad_req) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            st <= ST_WRITE;
          end
        end
        ST_WRITE: if (bus_ack_i) begin
          if (cmd_last)            st <= ST_POLL;
          else if (idx_q != 3'd5)  idx_q <= idx_q + 3'd1;
          if (op_q == OP_SERASE && idx_q == 3'd5) rem_q <= rem_q & ~pick;
        end
        ST_POLL: begin
          if (poll_hit) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end else if (poll_fail) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ack_o       = accept;
  assign busy_o      = (st != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign bus_req_o   = (st == ST_WRITE) || (st == ST_POLL);
  assign bus_we_o    = (st == ST_WRITE);
  assign bus_addr_o  = (st == ST_WRITE) ? cmd_addr : poll_addr;
  assign bus_wdata_o = (st == ST_WRITE) ? cmd_data : 8'h00;

  // R7
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) &&
                                $stable(bus_we_o) && $stable(bus_wdata_o));

  // R6
  refuse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !ack_o);

  // R6
  admit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> busy_o || done_o);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !bus_req_o);

  // R4
  poll_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_hit |=> done_o && !err_o);

  // R5
  timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_fail |=> done_o && err_o);

  // R8
  bad_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && bad_req |=> done_o && err_o && !bus_req_o);

  // R3
  sector_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WRITE) && (op_q == OP_SERASE) && (idx_q == 3'd5) |-> $countones(pick) == 1);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: tb/tb_nor_flash_seq.sv
`timescale 1ns/1ps
module tb_nor_flash_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i;
  logic        ack_o;
  logic [1:0]  op_i;
  logic [18:0] addr_i;
  logic [7:0]  data_i;
  logic [7:0]  sect_mask_i;
  logic [23:0] prog_limit_i, serase_limit_i, cerase_limit_i;
  logic        busy_o, done_o, err_o;
  logic        bus_req_o, bus_we_o;
  logic [18:0] bus_addr_o;
  logic [7:0]  bus_wdata_o;
  logic        bus_ack_i;
  logic        bus_rbit7_i;

  always #4 clk = ~clk;

  nor_flash_seq dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_o(ack_o), .op_i(op_i),
    .addr_i(addr_i), .data_i(data_i), .sect_mask_i(sect_mask_i),
    .prog_limit_i(prog_limit_i), .serase_limit_i(serase_limit_i),
    .cerase_limit_i(cerase_limit_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_ack_i(bus_ack_i), .bus_rbit7_i(bus_rbit7_i)
  );

  int checks = 0;
  int fails  = 0;

  // scoreboard of expected command writes {addr, data}
  logic [26:0] wq[$];
  string       cur_tag = "R1";

  // flash model state
  int          rd_left = 0;
  int          rd_cnt  = 0;
  bit          hang    = 1'b0;
  logic [7:0]  fin_val = 8'h00;
  logic [18:0] exp_poll = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("[TB] FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_w(input logic [18:0] a, input logic [7:0] d);
    wq.push_back({a, d});
  endtask

  task automatic push_unlock(input logic [7:0] code);
    push_w(19'h05555, 8'hAA);
    push_w(19'h02AAA, 8'h55);
    push_w(19'h05555, code);
  endtask

  // monitor / bus responder: pops expected writes, answers poll reads
  initial begin
    logic [26:0] exp;
    bus_ack_i   = 1'b0;
    bus_rbit7_i = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && bus_req_o) begin
        if (bus_we_o) begin
          if (wq.size() == 0) begin
            chk(1'b0, "R6", "unexpected bus write", {5'd0, bus_addr_o, bus_wdata_o}, 32'd0);
          end else begin
            exp = wq.pop_front();
            chk({bus_addr_o, bus_wdata_o} == exp, cur_tag, "command write",
                {5'd0, bus_addr_o, bus_wdata_o}, {5'd0, exp});
          end
        end else begin
          rd_cnt++;
          chk(bus_addr_o == exp_poll, "R4", "poll address",
              {13'd0, bus_addr_o}, {13'd0, exp_poll});
          if (hang || rd_left > 0) begin
            bus_rbit7_i = ~fin_val[7];
            if (rd_left > 0) rd_left--;
          end else begin
            bus_rbit7_i = fin_val[7];
          end
        end
        bus_ack_i = 1'b1;
        @(negedge clk);
        bus_ack_i = 1'b0;
      end
    end
  end

  // driver: pushes expected items, issues the request, waits for done
  task automatic run_op(input logic [1:0] op, input logic [18:0] a, input logic [7:0] d,
                        input logic [7:0] m, input int polls, input bit hg,
                        input bit exp_err, input bit poke, input string tag);
    int  n;
    bit  bad;
    bit  first;
    bad = (op == 2'd3) || (op == 2'd1 && m == 8'h00);
    cur_tag = tag;
    if (!bad) begin
      case (op)
        2'd0: begin
          push_unlock(8'hA0);
          push_w(a, d);
          exp_poll = a;
          fin_val  = d;
        end
        2'd1: begin
          push_unlock(8'h80);
          push_w(19'h05555, 8'hAA);
          push_w(19'h02AAA, 8'h55);
          first = 1'b1;
          for (int s = 0; s < 8; s++) begin
            if (m[s]) begin
              push_w({s[2:0], 16'h0000}, 8'h30);
              if (first) exp_poll = {s[2:0], 16'h0000};
              first = 1'b0;
            end
          end
          fin_val = 8'hFF;
        end
        default: begin
          push_unlock(8'h80);
          push_w(19'h05555, 8'hAA);
          push_w(19'h02AAA, 8'h55);
          push_w(19'h05555, 8'h10);
          exp_poll = '0;
          fin_val  = 8'hFF;
        end
      endcase
    end
    rd_left = polls;
    hang    = hg;
    rd_cnt  = 0;

    @(negedge clk);
    op_i = op; addr_i = a; data_i = d; sect_mask_i = m; req_i = 1'b1;
    #1;
    chk(ack_o == 1'b1, "R6", "ack when idle", {31'd0, ack_o}, 32'd1);
    @(negedge clk);
    req_i = 1'b0;
    n = 0;
    while (!done_o && n < 20000) begin
      if (poke && n == 6) begin
        req_i = 1'b1; op_i = 2'd2;
        #1;
        chk(ack_o == 1'b0 && busy_o == 1'b1, "R6", "request refused while busy",
            {30'd0, ack_o, busy_o}, 32'd1);
      end
      if (poke && n == 9) req_i = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(done_o == 1'b1, tag, "done seen", {31'd0, done_o}, 32'd1);
    chk(err_o == exp_err, exp_err ? (bad ? "R8" : "R5") : "R4", "error flag",
        {31'd0, err_o}, {31'd0, exp_err});
    chk(busy_o == 1'b0, "R6", "busy low with done", {31'd0, busy_o}, 32'd0);
    chk(wq.size() == 0, tag, "all command writes issued", wq.size(), 32'd0);
    if (bad)
      chk(rd_cnt == 0 && n == 0, "R8", "no bus activity, done next cycle", rd_cnt + n, 32'd0);
    else if (!hg)
      chk(rd_cnt == polls + 1, "R4", "poll read count", rd_cnt, polls + 1);
    else
      chk(n >= int'(prog_limit_i) && rd_cnt > 0, "R5", "no timeout before limit", n, prog_limit_i);
    @(negedge clk);
    chk(done_o == 1'b0, "R4", "done is one cycle", {31'd0, done_o}, 32'd0);
    wq.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("[TB] FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_i = 1'b0; op_i = 2'd0; addr_i = '0; data_i = '0;
    sect_mask_i = '0;
    prog_limit_i = 24'd30; serase_limit_i = 24'd500; cerase_limit_i = 24'd2000;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk(busy_o == 1'b0 && done_o == 1'b0 && err_o == 1'b0 && bus_req_o == 1'b0,
        "R9", "reset state", {28'd0, busy_o, done_o, err_o, bus_req_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_op(2'd0, 19'h12345, 8'h5A, 8'h00, 3,  1'b0, 1'b0, 1'b0, "R1"); // program, bit7=0
    run_op(2'd0, 19'h7FFFF, 8'hC3, 8'h00, 0,  1'b0, 1'b0, 1'b0, "R1"); // program, bit7=1, first read hits
    run_op(2'd2, 19'h00000, 8'h00, 8'h00, 40, 1'b0, 1'b0, 1'b0, "R2"); // chip erase, long poll under own limit
    run_op(2'd1, 19'h00000, 8'h00, 8'hA4, 4,  1'b0, 1'b0, 1'b0, "R3"); // sectors 2,5,7
    run_op(2'd1, 19'h00000, 8'h00, 8'h80, 1,  1'b0, 1'b0, 1'b0, "R3"); // single top sector
    run_op(2'd1, 19'h00000, 8'h00, 8'hFF, 2,  1'b0, 1'b0, 1'b0, "R3"); // all sectors
    run_op(2'd0, 19'h0ABCD, 8'h11, 8'h00, 0,  1'b1, 1'b1, 1'b0, "R5"); // timeout
    run_op(2'd0, 19'h40001, 8'hF0, 8'h00, 15, 1'b0, 1'b0, 1'b1, "R6"); // refused request mid-op
    run_op(2'd3, 19'h00000, 8'h00, 8'h00, 0,  1'b0, 1'b1, 1'b0, "R8"); // invalid op
    run_op(2'd1, 19'h00000, 8'h00, 8'h00, 0,  1'b0, 1'b1, 1'b0, "R8"); // empty mask
    run_op(2'd0, 19'h00010, 8'h80, 8'h00, 2,  1'b0, 1'b0, 1'b0, "R7"); // back-to-back transfers after errors

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule